// File: doc/BRIEF.md
# JTAG Test Access Port with Debug Register Bridge

This block is a test access port controller clocked by TCK. It runs the sixteen-state TAP state machine from TMS, holds a 4-bit instruction register, and selects among an identification register, a 1-bit bypass register, an 8-bit debug address register and a 64-bit debug data register. A host on the scan chain uses it to read and write the registers of an on-chip debug register file.

The debug side is a simple handshaked port in the TCK domain. Instruction 8 loads the target address. Instruction 9 reads the addressed register: the read request goes out in Capture-DR and the scan returns the value. Instruction 10 reads and then writes: the scan returns the old contents, and the shifted-in value is written at Update-DR. While a request waits for the acknowledge, the TAP stays in its Capture-DR or Update-DR state. The host therefore keeps clocking TCK until the request is served.

Top module: `jtag_dbg_tap`

## Requirements
- R1: When trst_n is asserted, and on every rising edge spent in Test-Logic-Reset, the instruction register is set to the identification code 4'b0001, both debug requests are low and tdo is 0. A 32-bit DR scan made next returns 0x000018FF.
- R2: The state machine follows the standard sixteen-state TAP graph. Five rising edges with TMS high, taken from within a DR scan, bring it to Test-Logic-Reset.
- R3: The instruction register is 4 bits wide and is shifted LSB first. It captures 4'b0001 in Capture-IR, and a new code takes effect only at Update-IR.
- R4: DR scans shift LSB first, with tdi entering the top bit of the selected length and tdo updated on the falling TCK edge (0 outside the Shift states). The lengths are 32 bits for code 1, 8 for code 8 and 64 for codes 9 and 10. Every other code selects a 1-bit register that captures 0.
- R5: Under code 8, the value shifted in drives dbg_addr from Update-DR onward, and Capture-DR loads the current address.
- R6: Under codes 9 and 10, dbg_rd_req is high only while the TAP is in Capture-DR. The TAP stays there until dbg_ack is high at a rising edge, and on that edge dbg_rdata is loaded into the shift register.
- R7: Code 9 never raises dbg_wr_req, so the debug register file is left unchanged whatever value is shifted in.
- R8: Under code 10, dbg_wr_req rises on entry to Update-DR, with dbg_wdata equal to the 64 bits shifted in. The TAP holds that state, dbg_addr and dbg_wdata until dbg_ack. The same scan returns the register's value from before the write.
- R9: At most one request is high at a time, and a request is low on the cycle after the rising edge at which dbg_ack was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| dbg_addr | output | 8 | Debug register address |
| dbg_rd_req | output | 1 | Read request, held until acknowledge |
| dbg_wr_req | output | 1 | Write request, held until acknowledge |
| dbg_wdata | output | 64 | Write data |
| dbg_rdata | input | 64 | Read data, valid with dbg_ack |
| dbg_ack | input | 1 | Acknowledge from the register file |

## Verification
The hardest case to reach is the TAP parked in Capture-DR or Update-DR for several TCK edges, waiting on a late acknowledge, while TMS is still being driven. The register-file model in the bench draws a fresh random latency of zero to three cycles for every request. The bench's TCK task keeps pulsing, with TMS and TDI unchanged, for as long as a request is outstanding and unacknowledged. A directed case also abandons a read scan partway through with five TMS-high edges. It then checks that the identification register is selected again.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;
  parameter int IR_W = 4;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] IR_IDCODE = IR_W'(1);
  localparam logic [IR_W-1:0] IR_DADDR  = IR_W'(8);
  localparam logic [IR_W-1:0] IR_DREAD  = IR_W'(9);
  localparam logic [IR_W-1:0] IR_DWRRD  = IR_W'(10);
  localparam logic [IR_W-1:0] IR_CAPPAT = IR_W'(1);
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_dbg_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       hold,
  output tap_state_e state_q
);
  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!hold) begin
      unique case (state_q)
        S_TLR:    state_d = tms ? S_TLR    : S_RTI;
        S_RTI:    state_d = tms ? S_SEL_DR : S_RTI;
        S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
        S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
        S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
        S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
        S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
        S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
        S_UPD_DR: state_d = tms ? S_SEL_DR : S_RTI;
        S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
        S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
        S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
        S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
        S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
        S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
        S_UPD_IR: state_d = tms ? S_SEL_DR : S_RTI;
        default:  state_d = S_TLR;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= S_TLR;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_dbg_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);
  logic [IR_W-1:0] sh_q, sh_d, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = (state == S_CAP_IR) || (state == S_SH_IR);
    sh_d  = (state == S_CAP_IR) ? IR_CAPPAT : {tdi, sh_q[IR_W-1:1]};
    ir_en = (state == S_UPD_IR) || (state == S_TLR);
    ir_d  = (state == S_TLR) ? IR_IDCODE : sh_q;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    ir_q <= IR_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir_lsb = sh_q[0];
endmodule

// File: rtl/jtag_dr_path.sv
module jtag_dr_path
  import jtag_dbg_pkg::*;
#(
  parameter int          DATA_W = 64,
  parameter int          ADDR_W = 8,
  parameter int          ID_W   = 32,
  parameter logic [31:0] ID_VAL = 32'h0000_18FF
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  input  logic              hold,
  input  logic [IR_W-1:0]   ir,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dr_lsb
);
  int                dr_len;
  logic [DATA_W-1:0] cap_val, dr_shift, dr_d;
  logic              dr_en, addr_en;

  always_comb begin
    unique case (ir)
      IR_IDCODE:          begin dr_len = ID_W;   cap_val = DATA_W'(ID_VAL); end
      IR_DADDR:           begin dr_len = ADDR_W; cap_val = DATA_W'(addr_q); end
      IR_DREAD, IR_DWRRD: begin dr_len = DATA_W; cap_val = rdata;           end
      default:            begin dr_len = 1;      cap_val = '0;              end
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_shift
    if (g < DATA_W - 1) begin : g_mid
      assign dr_shift[g] = (g == dr_len - 1) ? tdi :
                           ((g < dr_len - 1) ? dr_q[g+1] : 1'b0);
    end else begin : g_top
      assign dr_shift[g] = (g == dr_len - 1) ? tdi : 1'b0;
    end
  end

  always_comb begin
    dr_en   = ((state == S_CAP_DR) && !hold) || (state == S_SH_DR);
    dr_d    = (state == S_CAP_DR) ? cap_val : dr_shift;
    addr_en = (state == S_UPD_DR) && (ir == IR_DADDR);
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    dr_q <= '0;
    else if (dr_en) dr_q <= dr_d;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      addr_q <= '0;
    else if (addr_en) addr_q <= dr_q[ADDR_W-1:0];
  end

  assign dr_lsb = dr_q[0];
endmodule

// File: rtl/jtag_dbg_tap.sv
module jtag_dbg_tap
  import jtag_dbg_pkg::*;
#(
  parameter int          DATA_W = 64,
  parameter int          ADDR_W = 8,
  parameter logic [31:0] ID_VAL = 32'h0000_18FF
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic              dbg_rd_req,
  output logic              dbg_wr_req,
  output logic [DATA_W-1:0] dbg_wdata,
  input  logic [DATA_W-1:0] dbg_rdata,
  input  logic              dbg_ack
);
  tap_state_e        state_q;
  logic [IR_W-1:0]   ir_q;
  logic [DATA_W-1:0] dr_q;
  logic              ir_lsb, dr_lsb, hold;
  logic              rd_q, rd_d, wr_q, wr_d, tdo_q, tdo_d;
  logic              mem_op, enter_cap, enter_upd;

  assign hold = (rd_q || wr_q) && !dbg_ack;

  jtag_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .hold(hold), .state_q(state_q)
  );

  jtag_ir_unit u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state_q),
    .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  jtag_dr_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state_q), .hold(hold),
    .ir(ir_q), .rdata(dbg_rdata), .dr_q(dr_q), .addr_q(dbg_addr),
    .dr_lsb(dr_lsb)
  );

  // Request control: read opens on entry to Capture-DR, write on entry to Update-DR.
  always_comb begin
    mem_op    = (ir_q == IR_DREAD) || (ir_q == IR_DWRRD);
    enter_cap = (state_q == S_SEL_DR) && !tms;
    enter_upd = ((state_q == S_EX1_DR) || (state_q == S_EX2_DR)) && tms;
    rd_d = rd_q;
    if (rd_q && dbg_ack)        rd_d = 1'b0;
    else if (enter_cap && mem_op) rd_d = 1'b1;
    wr_d = wr_q;
    if (wr_q && dbg_ack)                   wr_d = 1'b0;
    else if (enter_upd && ir_q == IR_DWRRD) wr_d = 1'b1;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_SH_IR: tdo_d = ir_lsb;
      S_SH_DR: tdo_d = dr_lsb;
      default: tdo_d = 1'b0;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo_q <= 1'b0;
    else         tdo_q <= tdo_d;
  end

  assign tdo        = tdo_q;
  assign dbg_rd_req = rd_q;
  assign dbg_wr_req = wr_q;
  assign dbg_wdata  = dr_q;
endmodule

// File: rtl/jtag_dbg_tap_chk.sv
module jtag_dbg_tap_chk
  import jtag_dbg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input logic              tck,
  input logic              trst_n,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir,
  input logic              dbg_rd_req,
  input logic              dbg_wr_req,
  input logic              dbg_ack,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic [DATA_W-1:0] dbg_wdata
);
  a_r1_tlr_selects_id: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_TLR |=> ir == IR_IDCODE);

  a_r6_rd_only_in_capture: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_rd_req |-> state == S_CAP_DR);

  a_r6_rd_stall: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_rd_req && !dbg_ack |=> dbg_rd_req && state == S_CAP_DR);

  a_r7_read_no_write: assert property (@(posedge tck) disable iff (!trst_n)
    ir == IR_DREAD |-> !dbg_wr_req);

  a_r8_wr_hold: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_wr_req && !dbg_ack |=> dbg_wr_req && state == S_UPD_DR
      && $stable(dbg_addr) && $stable(dbg_wdata));

  a_r9_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    !(dbg_rd_req && dbg_wr_req));

  a_r9_drop_after_ack: assert property (@(posedge tck) disable iff (!trst_n)
    (dbg_rd_req || dbg_wr_req) && dbg_ack |=> !dbg_rd_req && !dbg_wr_req);
endmodule

bind jtag_dbg_tap jtag_dbg_tap_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .state(state_q), .ir(ir_q),
  .dbg_rd_req(dbg_rd_req), .dbg_wr_req(dbg_wr_req), .dbg_ack(dbg_ack),
  .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata)
);

// File: tb/jtag_dbg_tap_bench.sv
`timescale 1ns/1ps
module jtag_dbg_tap_bench;
  logic        tck, trst_n, tms, tdi, tdo;
  logic [7:0]  dbg_addr;
  logic        dbg_rd_req, dbg_wr_req, dbg_ack;
  logic [63:0] dbg_wdata, dbg_rdata;

  int checks = 0, fails = 0, overlap = 0, wr_cnt = 0, lat = 0, cnt = 0;
  logic [63:0] mem     [256];
  logic [63:0] exp_mem [256];

  jtag_dbg_tap u_jtag_dbg_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .dbg_addr(dbg_addr), .dbg_rd_req(dbg_rd_req), .dbg_wr_req(dbg_wr_req),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_ack(dbg_ack)
  );

  function automatic logic [63:0] init_val(input int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  // Register-file model: acks after a random latency, on the falling edge.
  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dbg_ack <= 1'b0;
      cnt = 0;
    end else begin
      if (dbg_rd_req && dbg_wr_req) overlap++;
      if (dbg_ack) dbg_ack <= 1'b0;
      else if (dbg_rd_req || dbg_wr_req) begin
        if (cnt >= lat) begin
          dbg_ack <= 1'b1;
          cnt = 0;
          lat = int'($urandom % 4);
          if (dbg_wr_req) begin
            mem[dbg_addr] = dbg_wdata;
            wr_cnt++;
          end else dbg_rdata <= mem[dbg_addr];
        end else cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One TCK period at 50 MHz; repeats while a request is waiting on its acknowledge.
  task automatic pulse(input logic m, input logic d);
    logic stall;
    int guard = 0;
    tms = m;
    tdi = d;
    do begin
      #5;
      stall = (dbg_rd_req || dbg_wr_req) && !dbg_ack;
      tck = 1'b1;
      #10;
      tck = 1'b0;
      #5;
      guard++;
    end while (stall && guard < 100);
  endtask

  task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
    pulse(1, 0); pulse(1, 0); pulse(0, 0); pulse(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      pulse(i == 3, code[i]);
    end
    pulse(1, 0); pulse(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    pulse(1, 0); pulse(0, 0); pulse(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      pulse(i == n - 1, din[i]);
    end
    pulse(1, 0); pulse(0, 0);
  endtask

  task automatic set_addr(input logic [7:0] a);
    logic [3:0]  c;
    logic [63:0] o;
    ir_scan(4'd8, c);
    dr_scan(8, 64'(a), o);
  endtask

  task automatic run_all();
    logic [3:0]  c;
    logic [63:0] o, v;
    logic [7:0]  a;
    int          w0;
    void'($urandom(32'd4692));
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    tck = 0; tms = 1; tdi = 0; trst_n = 0; dbg_rdata = '0;
    #15;
    check("R1 reset rd_req", 64'(dbg_rd_req), 64'd0);
    check("R1 reset wr_req", 64'(dbg_wr_req), 64'd0);
    check("R1 reset tdo", 64'(tdo), 64'd0);
    trst_n = 1;
    #5;
    pulse(0, 0);
    dr_scan(32, 64'h0, o);
    check("R1 idcode after reset", o, 64'h18FF);

    ir_scan(4'd9, c);
    check("R3 ir capture pattern", 64'(c), 64'd1);
    ir_scan(4'd15, c);
    dr_scan(8, 64'hB5, o);
    check("R4 bypass one-bit delay", o, 64'h6A);

    set_addr(8'h3C);
    ir_scan(4'd8, c);
    dr_scan(8, 64'hFF, o);
    check("R5 address capture", o, 64'h3C);
    check("R5 dbg_addr port", 64'(dbg_addr), 64'hFF);

    ir_scan(4'd9, c);
    w0 = wr_cnt;
    dr_scan(64, 64'hDEAD_BEEF_0BAD_F00D, o);
    check("R6 read data", o, exp_mem[8'hFF]);
    dr_scan(64, 64'h0, o);
    check("R7 read leaves register", o, exp_mem[8'hFF]);
    check("R7 no write issued", 64'(wr_cnt - w0), 64'd0);

    set_addr(8'h10);
    ir_scan(4'd10, c);
    v = 64'hFEED_0000_1234_5678;
    dr_scan(64, v, o);
    check("R8 old value returned", o, exp_mem[8'h10]);
    exp_mem[8'h10] = v;
    check("R8 dbg_addr during write", 64'(dbg_addr), 64'h10);
    ir_scan(4'd9, c);
    dr_scan(64, 64'h0, o);
    check("R8 new value stored", o, v);

    // Abandon a read scan midway with five TMS-high edges.
    pulse(1, 0); pulse(0, 0); pulse(0, 0); pulse(0, 1); pulse(0, 0);
    for (int i = 0; i < 5; i++) pulse(1, 0);
    pulse(0, 0);
    dr_scan(32, 64'h0, o);
    check("R2 tms reset selects idcode", o, 64'h18FF);

    for (int k = 0; k < 40; k++) begin
      int op = int'($urandom % 3);
      a = 8'($urandom);
      if (op == 0) begin
        set_addr(a);
        ir_scan(4'd9, c);
        dr_scan(64, {$urandom, $urandom}, o);
        check("R6 random read", o, exp_mem[a]);
      end else if (op == 1) begin
        set_addr(a);
        ir_scan(4'd10, c);
        v = {$urandom, $urandom};
        dr_scan(64, v, o);
        check("R8 random write old value", o, exp_mem[a]);
        exp_mem[a] = v;
      end else begin
        logic [3:0] code = 4'($urandom);
        if (code == 4'd1 || code == 4'd8 || code == 4'd9 || code == 4'd10) code = 4'd0;
        ir_scan(code, c);
        v = 64'($urandom % 65536);
        dr_scan(16, v, o);
        check("R4 random bypass", o, {48'h0, v[14:0], 1'b0});
      end
    end
    for (int i = 0; i < 256; i++) check("R8 final register file", mem[i], exp_mem[i]);
    check("R9 requests never overlapped", 64'(overlap), 64'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule